// File: doc/BRIEF.md
# Thermal clock modulation controller

This block slows a core down when it runs hot by pulsing a clock enable on and off in a repeating pattern. The enable goes to a clock gating cell outside the block. A period has eight slots, and each slot lasts `SLOT_CYC` cycles. A duty code k keeps the clock running for the first k slots and stops it for the remaining 8−k slots. When throttling is idle, the enable stays high.

Throttling has two sources, and both are controlled through a 5-bit control register:

- **Automatic throttling** starts when a temperature comparator reports that the die is above its trip level. Its duty is fixed at 4 of 8 slots. It stops only when a second comparator reports that the temperature has dropped below a lower release level.
- **On-demand throttling** is started by software, which also chooses the duty.

If automatic throttling is active, it wins over on-demand throttling. Interrupt requests that arrive while the clock is stopped are held in a latch. They are released only while the clock is running.

Top module: `therm_mod_ctrl`

## Requirements
- R1: While reset is held, and right after it, `clk_en_o` is 1, `throttle_o` is 0 and `irq_pend_o` is 0. The control register resets to 5'b00001, which means automatic mode is enabled and on-demand mode is off.
- R2: Whenever `throttle_o` is 0, `clk_en_o` is 1.
- R3: The control register fields are: bit 4 = on-demand request, bits 3:1 = duty code, bit 0 = automatic enable. A write that sets bit 4 raises `throttle_o` two edges after the write edge, whatever the temperature inputs are. Each period then gives k·SLOT_CYC cycles of enable high followed by (8−k)·SLOT_CYC cycles of enable low, where k is the duty code.
- R4: In on-demand mode, duty code 3'b000 gives the same pattern as code 3'b100.
- R5: When bit 0 is set and `hot_i` is sampled high, throttling starts two edges later with a duty of 4 slots on and 4 slots off.
- R6: While the automatic hot state is held, the duty is 4 slots whatever the on-demand request and duty code say.
- R7: Once the automatic hot state is entered, it is held until `cool_i` is sampled high. A low `hot_i` alone does not release it.
- R8: A change of request or duty, and the end of throttling, take effect only at the end of an 8-slot period. While throttling, `clk_en_o` changes only at slot boundaries.
- R9: While bit 0 is clear, `hot_i` has no effect.
- R10: Each `irq_i` pulse sets a pending latch. The latch is presented on `irq_pend_o` only in a cycle where `clk_en_o` is 1, and it clears after one such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hot_i | input | 1 | Temperature is above the trip level |
| cool_i | input | 1 | Temperature is below the release level |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 5 | Control register write data |
| irq_i | input | 1 | Interrupt request pulse |
| clk_en_o | output | 1 | Registered clock enable for the gating cell |
| throttle_o | output | 1 | Throttling is active |
| irq_pend_o | output | 1 | Pending interrupt, shown only while the clock is enabled |

## Verification
The bench builds the block with `SLOT_CYC` = 3, which makes one period 24 cycles long. At that length, many periods fit into a short run. The short period lets the bench reach several corner cases:

- every duty code, including the reserved code;
- writes that land in the middle of a period;
- release of throttling at the end of a period;
- a hot condition that starts and clears while on-demand throttling is already running.

Each slot is three cycles long, so the checker's slot-phase counter has to wrap. This shows that the enable moves only on slot edges and never inside a slot.

// File: rtl/therm_mod_pkg.sv
package therm_mod_pkg;
  localparam int DUTY_W   = 3;
  localparam int SLOTS    = 1 << DUTY_W;
  localparam int HALF     = SLOTS / 2;
  localparam int CTRL_W   = DUTY_W + 2;

  typedef struct packed {
    logic              od_req;
    logic [DUTY_W-1:0] duty;
    logic              auto_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{od_req: 1'b0, duty: '0, auto_en: 1'b1};

  // automatic hot state forces half duty; reserved code 0 maps to half
  function automatic logic [DUTY_W-1:0] eff_duty(input logic hot, input logic [DUTY_W-1:0] code);
    if (hot || code == '0) return DUTY_W'(HALF);
    return code;
  endfunction
endpackage

// File: rtl/therm_ctrl_reg.sv
module therm_ctrl_reg
  import therm_mod_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= CTRL_RST;
    else if (wr_en_i) ctrl_q <= ctrl_t'(wr_data_i);
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/therm_hyst.sv
module therm_hyst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hot_i,
  input  logic cool_i,
  output logic hot_o
);
  logic hot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hot_q <= 1'b0;
    else if (!en_i)  hot_q <= 1'b0;
    else if (hot_i)  hot_q <= 1'b1;
    else if (cool_i) hot_q <= 1'b0;
  end

  assign hot_o = hot_q;
endmodule

// File: rtl/therm_mod_seq.sv
module therm_mod_seq
  import therm_mod_pkg::*;
#(
  parameter int SLOT_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              active_o,
  output logic              en_o
);
  localparam int CYC_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(SLOT_CYC - 1);
  localparam logic [DUTY_W-1:0] SLOT_LAST = DUTY_W'(SLOTS - 1);

  logic              act_q, act_d, en_q, en_d;
  logic [DUTY_W-1:0] duty_q, duty_d, slot_q, slot_d;
  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic              slot_end, per_end;

  assign slot_end = (cyc_q == CYC_LAST);
  assign per_end  = slot_end && (slot_q == SLOT_LAST);

  always_comb begin
    act_d  = act_q;
    duty_d = duty_q;
    slot_d = slot_q;
    cyc_d  = cyc_q;
    if (!act_q) begin
      if (req_i) begin
        act_d  = 1'b1;
        duty_d = duty_i;
        slot_d = '0;
        cyc_d  = '0;
      end
    end else if (per_end) begin
      slot_d = '0;
      cyc_d  = '0;
      if (req_i) duty_d = duty_i;
      else       act_d  = 1'b0;
    end else if (slot_end) begin
      cyc_d  = '0;
      slot_d = slot_q + 1'b1;
    end else begin
      cyc_d  = cyc_q + 1'b1;
    end
    en_d = !act_d || (slot_d < duty_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      duty_q <= DUTY_W'(HALF);
      slot_q <= '0;
      cyc_q  <= '0;
      en_q   <= 1'b1;
    end else begin
      act_q  <= act_d;
      duty_q <= duty_d;
      slot_q <= slot_d;
      cyc_q  <= cyc_d;
      en_q   <= en_d;
    end
  end

  assign active_o = act_q;
  assign en_o     = en_q;
endmodule

// File: rtl/therm_irq_hold.sv
module therm_irq_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic en_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= irq_i || (pend_q && !en_i);
  end

  assign pend_o = pend_q && en_i;
endmodule

// File: rtl/therm_mod_ctrl.sv
module therm_mod_ctrl
  import therm_mod_pkg::*;
#(
  parameter int SLOT_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hot_i,
  input  logic              cool_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              irq_i,
  output logic              clk_en_o,
  output logic              throttle_o,
  output logic              irq_pend_o
);
  ctrl_t             ctrl;
  logic              auto_hot;
  logic              req;
  logic [DUTY_W-1:0] duty_req;

  therm_ctrl_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .ctrl_o   (ctrl)
  );

  therm_hyst u_hyst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ctrl.auto_en),
    .hot_i (hot_i),
    .cool_i(cool_i),
    .hot_o (auto_hot)
  );

  assign req      = auto_hot || ctrl.od_req;
  assign duty_req = eff_duty(auto_hot, ctrl.duty);

  therm_mod_seq #(.SLOT_CYC(SLOT_CYC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .duty_i  (duty_req),
    .active_o(throttle_o),
    .en_o    (clk_en_o)
  );

  therm_irq_hold u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .irq_i (irq_i),
    .en_i  (clk_en_o),
    .pend_o(irq_pend_o)
  );
endmodule

// File: rtl/therm_mod_ctrl_chk.sv
module therm_mod_ctrl_chk #(
  parameter int SLOT_CYC = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic clk_en_o,
  input logic throttle_o,
  input logic irq_pend_o
);
  localparam int PW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             ph_q <= '0;
    else if (!throttle_o)                    ph_q <= '0;
    else if (ph_q == PW'(SLOT_CYC - 1))      ph_q <= '0;
    else                                     ph_q <= ph_q + 1'b1;
  end

  AST_IDLE_EN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !throttle_o |-> clk_en_o); // R2
  AST_IRQ_ON_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pend_o |-> clk_en_o); // R10
  AST_START_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(throttle_o) |-> clk_en_o); // R3
  AST_END_AFTER_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(throttle_o) |-> !$past(clk_en_o)); // R8
  AST_EN_SLOT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (throttle_o && $past(throttle_o) && !$stable(clk_en_o)) |-> (ph_q == '0)); // R8
endmodule

bind therm_mod_ctrl therm_mod_ctrl_chk #(.SLOT_CYC(SLOT_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clk_en_o  (clk_en_o),
  .throttle_o(throttle_o),
  .irq_pend_o(irq_pend_o)
);

// File: tb/tb_therm_mod_ctrl.sv
`timescale 1ns/1ps
module tb_therm_mod_ctrl;
  localparam int S   = 3;
  localparam int PER = 8 * S;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hot_i = 1'b0, cool_i = 1'b1, wr_en_i = 1'b0, irq_i = 1'b0;
  logic [4:0] wr_data_i = 5'd0;
  logic       clk_en_o, throttle_o, irq_pend_o;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  therm_mod_ctrl #(.SLOT_CYC(S)) dut (.*);

  // behavioural reference model
  int m_reg, m_hot, m_act, m_duty, m_pos, m_pend;

  function automatic int m_en();
    return (m_act == 0 || m_pos < m_duty * S) ? 1 : 0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_reg = 1; m_hot = 0; m_act = 0; m_duty = 4; m_pos = 0; m_pend = 0;
    end else begin
      int en_now, req, code, dr, n_hot;
      en_now = m_en();
      req  = (m_hot != 0 || (m_reg & 16) != 0) ? 1 : 0;
      code = (m_reg >> 1) & 7;
      dr   = (m_hot != 0 || code == 0) ? 4 : code;
      if (m_act == 0) begin
        if (req != 0) begin m_act = 1; m_duty = dr; m_pos = 0; end
      end else if (m_pos == PER - 1) begin
        m_pos = 0;
        if (req != 0) m_duty = dr; else m_act = 0;
      end else m_pos++;
      n_hot = m_hot;
      if ((m_reg & 1) == 0) n_hot = 0;
      else if (hot_i) n_hot = 1;
      else if (cool_i) n_hot = 0;
      m_hot = n_hot;
      if (wr_en_i) m_reg = int'(wr_data_i);
      m_pend = (irq_i || (m_pend != 0 && en_now == 0)) ? 1 : 0;
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", t, $time, act, exp);
    end
  endtask

  always @(negedge clk_i) if (rst_ni && !done) begin
    chk({tag, " clk_en_o"},   int'(clk_en_o),   m_en());
    chk({tag, " throttle_o"}, int'(throttle_o), m_act);
    chk({tag, " irq_pend_o"}, int'(irq_pend_o), (m_pend != 0 && m_en() != 0) ? 1 : 0);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input logic [4:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    step(1);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_irq();
    irq_i = 1'b1; step(1); irq_i = 1'b0;
  endtask

  int on_cnt;

  initial begin
    step(2);
    chk("R1 en in reset", int'(clk_en_o), 1);
    chk("R1 throttle in reset", int'(throttle_o), 0);
    chk("R1 irq in reset", int'(irq_pend_o), 0);
    rst_ni = 1'b1;
    step(1);
    chk("R1 en after reset", int'(clk_en_o), 1);

    tag = "R2"; step(6);
    tag = "R10"; pulse_irq(); step(3);

    // on-demand, duty 3, auto off, hot toggling ignored (R3, R9)
    tag = "R3";
    wr(5'b1_011_0);
    hot_i = 1'b1;
    step(1);
    chk("R3 throttle two edges after write", int'(throttle_o), 1);
    on_cnt = 0;
    for (int i = 0; i < PER; i++) begin
      if (clk_en_o) on_cnt++;
      step(1);
    end
    chk("R3 on cycles per period", on_cnt, 3 * S);
    tag = "R10"; pulse_irq(); step(PER);
    // mid-period change to reserved code
    tag = "R8"; step(5); wr(5'b1_000_0); step(PER);
    tag = "R4"; step(2 * PER);
    tag = "R3"; wr(5'b1_111_0); step(2 * PER);
    wr(5'b1_001_0); step(2 * PER);
    tag = "R10"; step(S + 2); pulse_irq(); step(PER);
    // release at end of period
    tag = "R8"; wr(5'b0_001_0); step(3);
    chk("R8 still throttling after clear", int'(throttle_o), 1);
    step(2 * PER);
    chk("R8 released", int'(throttle_o), 0);
    // hot ignored while auto disabled
    tag = "R9"; step(PER);
    chk("R9 hot ignored", int'(throttle_o), 0);
    hot_i = 1'b0;

    // automatic with hysteresis
    tag = "R5"; wr(5'b0_000_1);
    cool_i = 1'b0; hot_i = 1'b1; step(1); hot_i = 1'b0; step(1);
    chk("R5 auto started", int'(throttle_o), 1);
    step(2 * PER);
    tag = "R7"; step(PER);
    chk("R7 held without cool", int'(throttle_o), 1);
    cool_i = 1'b1; step(1); cool_i = 1'b0; step(2 * PER);
    chk("R7 released after cool", int'(throttle_o), 0);

    // precedence: on-demand 7 with auto hot
    tag = "R6"; wr(5'b1_111_1); step(7);
    hot_i = 1'b1; step(1); hot_i = 1'b0; step(3 * PER);
    cool_i = 1'b1; step(1); cool_i = 1'b0;
    tag = "R8"; step(2 * PER);
    wr(5'b0_000_1); step(2 * PER);
    tag = "R2"; step(10);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule